// File: doc/BRIEF.md
# Core Image Loader With Shared-Memory Slot

This block brings a processor core up. On a start request it copies a fixed-size program image into the core's private register file. The image is read word by word from shared memory. Shared memory is reached only through a time slot that rotates among eight cores, so the loader takes one word in each slot it is granted. After the image words, it zeroes the top group of register-file locations, which hold the special registers. It then releases the core to begin execution at local address zero.

All register-file locations, including the cleared ones, are paced by the slot rotation. Once the first slot after acceptance is granted, the rest of the load therefore takes a fixed number of cycles. The release lands on a fixed offset from that first granted slot. A cycle counter output makes this offset visible.

Top module: `core_image_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `busy`, `run`, `mem_rd_en` and `rf_we` are 0, `core_rst` is 1 and `cyc_cnt` is 0.
- R2: A `start_req` sampled while the loader is idle is accepted. `busy` is 1 from the next cycle, and `core_rst` is 1 whenever `busy` is 1, including on a restart after an earlier release.
- R3: A shared-memory read (`mem_rd_en` = 1) occurs only in a cycle where `slot_grant` is 1, and never while `busy` is 0. With a grant that recurs every 8 cycles, the first read comes within 8 cycles of `busy` rising.
- R4: Each load issues exactly 496 reads. The addresses start at the accepted `start_addr` and rise by one per read.
- R5: The word returned for read number i (0 to 495) appears on `mem_rd_data` in the cycle after the read. It is written into register-file location i in that same cycle.
- R6: After the reads, locations 496 to 511 are written with zero, one location per granted slot and in ascending order. The last write of a load is zero to location 511. A load makes 512 register-file writes in total.
- R7: `run` is 1 for exactly one cycle: the cycle after the write to location 511. In that cycle `run_pc` is 0 and `busy` is 0. `core_rst` is 0 from that cycle until the next accepted start.
- R8: `cyc_cnt` is 0 in the cycle after the first granted slot of a load and rises by one per cycle from there. In the `run` cycle it reads 4088, a multiple of 8.
- R9: A `start_req` that arrives while a load is in progress is ignored. The read address sequence and the loaded data are unaffected.
- R10: While no slot is granted, a load in progress issues no reads, keeps `busy` at 1 and does not move toward release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to start a load |
| start_addr | input | 16 | Shared-memory word address of the image |
| slot_grant | input | 1 | This core owns the shared-memory slot in this cycle |
| mem_rd_en | output | 1 | Shared-memory read strobe |
| mem_rd_addr | output | 16 | Shared-memory read word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 9 | Register-file write location |
| rf_wdata | output | 32 | Register-file write data |
| core_rst | output | 1 | Holds the core in reset |
| run | output | 1 | One-cycle release pulse |
| run_pc | output | 9 | Start address of the core at release |
| busy | output | 1 | Load in progress |
| cyc_cnt | output | 16 | Cycles since the first granted slot of the load |

## Verification
`busy` is due one cycle after a start is sampled. The first read follows within eight cycles, on the granted slot. Each image word reaches the register file one cycle after its read. `run` arrives 4089 cycles after the first granted slot, with `cyc_cnt` at 4088. The bench drives inputs and reads outputs on the falling edge, and counts the cycles from acceptance to the first read itself. It checks the release values in the same falling-edge window where it first sees `run`, and checks that `run` has dropped one falling edge later. Register-file contents are compared only after the release, against words the bench computes from the requested address.

// File: rtl/cil_pkg.sv
package cil_pkg;

    localparam int RF_WORDS_D   = 512;
    localparam int RF_SPECIAL_D = 16;
    localparam int SLOT_COUNT_D = 8;
    localparam int WORD_W_D     = 32;
    localparam int SRC_AW_D     = 16;
    localparam int CNT_W_D      = 16;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_COPY = 2'd1,
        LD_GO   = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic fetch;
        logic clear;
        logic final_step;
    } slot_op_t;

    // What a granted slot does for register-file step idx.
    function automatic slot_op_t decode_op(input logic grant,
                                           input int unsigned idx,
                                           input int unsigned n_load,
                                           input int unsigned n_total);
        slot_op_t op;
        op.fetch      = grant && (idx < n_load);
        op.clear      = grant && (idx >= n_load);
        op.final_step = grant && (idx == n_total - 1);
        return op;
    endfunction

endpackage

// File: rtl/cil_seq.sv
module cil_seq
    import cil_pkg::*;
#(
    parameter int RF_WORDS   = RF_WORDS_D,
    parameter int RF_SPECIAL = RF_SPECIAL_D,
    parameter int SRC_AW     = SRC_AW_D
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_req,
    input  logic [SRC_AW-1:0]           start_addr,
    input  logic                        slot_grant,
    output ld_state_e                   state,
    output logic [$clog2(RF_WORDS)-1:0] step,
    output logic [SRC_AW-1:0]           src_addr,
    output logic                        fetch,
    output logic                        clear,
    output logic                        first_grant
);
    localparam int RF_AW      = $clog2(RF_WORDS);
    localparam int LOAD_WORDS = RF_WORDS - RF_SPECIAL;

    ld_state_e         state_q;
    logic [RF_AW-1:0]  step_q;
    logic [SRC_AW-1:0] src_q;
    slot_op_t          op;

    always_comb begin
        if (state_q == LD_COPY)
            op = decode_op(slot_grant, 32'(step_q), LOAD_WORDS, RF_WORDS);
        else
            op = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            step_q  <= '0;
            src_q   <= '0;
        end else begin
            case (state_q)
                LD_IDLE: begin
                    if (start_req) begin
                        state_q <= LD_COPY;
                        step_q  <= '0;
                        src_q   <= start_addr;
                    end
                end
                LD_COPY: begin
                    if (op.fetch || op.clear)
                        step_q <= step_q + 1'b1;
                    if (op.fetch)
                        src_q <= src_q + 1'b1;
                    if (op.final_step)
                        state_q <= LD_GO;
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign state       = state_q;
    assign step        = step_q;
    assign src_addr    = src_q;
    assign fetch       = op.fetch;
    assign clear       = op.clear;
    assign first_grant = (op.fetch || op.clear) && (step_q == '0);

    AST_HOLD_WITHOUT_SLOT: assert property (@(posedge clk) disable iff (rst)
        (state_q == LD_COPY && !slot_grant) |=> (state_q == LD_COPY && $stable(step_q))) // R10
        else $error("step moved without a slot");

endmodule

// File: rtl/cil_wb.sv
module cil_wb #(
    parameter int RF_AW  = 9,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              clear,
    input  logic [RF_AW-1:0]  step,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rf_we,
    output logic [RF_AW-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata
);
    logic             pend_q;
    logic [RF_AW-1:0] pend_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else begin
            pend_q     <= fetch;
            pend_idx_q <= step;
        end
    end

    always_comb begin
        if (pend_q) begin
            rf_we    = 1'b1;
            rf_waddr = pend_idx_q;
            rf_wdata = rd_data;
        end else begin
            rf_we    = clear;
            rf_waddr = step;
            rf_wdata = '0;
        end
    end

    AST_NO_WRITE_CLASH: assert property (@(posedge clk) disable iff (rst)
        !(pend_q && clear)) // R6
        else $error("data write and clear in one cycle");

endmodule

// File: rtl/cil_cyc.sv
module cil_cyc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (advance)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/core_image_loader.sv
module core_image_loader
    import cil_pkg::*;
#(
    parameter int RF_WORDS   = RF_WORDS_D,
    parameter int RF_SPECIAL = RF_SPECIAL_D,
    parameter int SLOT_COUNT = SLOT_COUNT_D,
    parameter int WORD_W     = WORD_W_D,
    parameter int SRC_AW     = SRC_AW_D,
    parameter int CNT_W      = CNT_W_D
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start_req,
    input  logic [SRC_AW-1:0]           start_addr,
    input  logic                        slot_grant,
    output logic                        mem_rd_en,
    output logic [SRC_AW-1:0]           mem_rd_addr,
    input  logic [WORD_W-1:0]           mem_rd_data,
    output logic                        rf_we,
    output logic [$clog2(RF_WORDS)-1:0] rf_waddr,
    output logic [WORD_W-1:0]           rf_wdata,
    output logic                        core_rst,
    output logic                        run,
    output logic [$clog2(RF_WORDS)-1:0] run_pc,
    output logic                        busy,
    output logic [CNT_W-1:0]            cyc_cnt
);
    localparam int RF_AW     = $clog2(RF_WORDS);
    localparam int SLOT_BITS = $clog2(SLOT_COUNT);
    localparam logic [RF_AW-1:0] ENTRY_PC = '0;
    localparam logic [RF_AW-1:0] TOP_LOC  = RF_AW'(RF_WORDS - 1);

    ld_state_e         state;
    logic [RF_AW-1:0]  step;
    logic [SRC_AW-1:0] src_addr;
    logic              fetch;
    logic              clear;
    logic              first_grant;
    logic              advance;
    logic              core_live_q;

    cil_seq #(
        .RF_WORDS   (RF_WORDS),
        .RF_SPECIAL (RF_SPECIAL),
        .SRC_AW     (SRC_AW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .start_addr  (start_addr),
        .slot_grant  (slot_grant),
        .state       (state),
        .step        (step),
        .src_addr    (src_addr),
        .fetch       (fetch),
        .clear       (clear),
        .first_grant (first_grant)
    );

    cil_wb #(
        .RF_AW  (RF_AW),
        .WORD_W (WORD_W)
    ) u_wb (
        .clk      (clk),
        .rst      (rst),
        .fetch    (fetch),
        .clear    (clear),
        .step     (step),
        .rd_data  (mem_rd_data),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    assign advance = ((state == LD_COPY) && (step != '0)) || (state == LD_GO);

    cil_cyc #(
        .CNT_W (CNT_W)
    ) u_cyc (
        .clk     (clk),
        .rst     (rst),
        .restart (first_grant),
        .advance (advance),
        .cnt     (cyc_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            core_live_q <= 1'b0;
        else if (state == LD_GO)
            core_live_q <= 1'b1;
        else if (state == LD_IDLE && start_req)
            core_live_q <= 1'b0;
    end

    assign mem_rd_en   = fetch;
    assign mem_rd_addr = src_addr;
    assign run         = (state == LD_GO);
    assign busy        = (state == LD_COPY);
    assign core_rst    = !(core_live_q || run);
    assign run_pc      = ENTRY_PC;

    AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        run |=> !run) // R7
        else $error("run longer than one cycle");

    AST_RUN_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        run |-> $past(rf_we && rf_waddr == TOP_LOC && rf_wdata == '0)) // R6
        else $error("release not preceded by top clear");

    AST_RUN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        run |-> (cyc_cnt[SLOT_BITS-1:0] == '0)) // R8
        else $error("release off the slot rotation");

    AST_BUSY_HOLDS_CORE: assert property (@(posedge clk) disable iff (rst)
        busy |-> core_rst) // R2
        else $error("core out of reset during load");

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_rd_en) // R3
        else $error("read outside a load");

    AST_READ_IN_SLOT: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> slot_grant) // R3
        else $error("read without slot");

endmodule

// File: tb/core_image_loader_test.sv
module core_image_loader_test;

    localparam int GRANT_ID = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic [15:0] start_addr = '0;
    logic        slot_grant;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        rf_we;
    logic [8:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        core_rst;
    logic        run;
    logic [8:0]  run_pc;
    logic        busy;
    logic [15:0] cyc_cnt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [2:0]  slot_q = '0;
    logic        grant_en = 1'b1;
    logic [31:0] rf_model [512];

    // monitor state
    logic        mon_clear = 1'b0;
    logic [15:0] exp_base = '0;
    logic [15:0] exp_addr;
    int rd_cnt, wr_cnt, addr_err, grant_err;

    always #2.5 clk = ~clk;

    core_image_loader uut (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .start_addr  (start_addr),
        .slot_grant  (slot_grant),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .core_rst    (core_rst),
        .run         (run),
        .run_pc      (run_pc),
        .busy        (busy),
        .cyc_cnt     (cyc_cnt)
    );

    function automatic logic [31:0] mem_word(input logic [15:0] a);
        return {a ^ 16'hC35A, ~a};
    endfunction

    assign slot_grant = grant_en && (slot_q == 3'(GRANT_ID));

    always @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_q + 3'd1;
        if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
        if (rst) begin
            for (int i = 0; i < 512; i++) rf_model[i] <= 32'hBAD0_0000 | 32'(i);
        end else if (rf_we) begin
            rf_model[rf_waddr] <= rf_wdata;
        end
    end

    always @(negedge clk) begin
        if (mon_clear) begin
            rd_cnt = 0; wr_cnt = 0; addr_err = 0; grant_err = 0;
            exp_addr = exp_base;
        end else begin
            if (mem_rd_en) begin
                if (!slot_grant) grant_err++;
                if (mem_rd_addr != exp_addr) addr_err++;
                exp_addr = exp_addr + 16'd1;
                rd_cnt++;
            end
            if (rf_we) wr_cnt++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_req = 1'b0; grant_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic arm_monitor(input logic [15:0] base);
        exp_base = base;
        mon_clear = 1'b1;
        @(negedge clk);
        mon_clear = 1'b0;
    endtask

    // Drive a start at a falling edge; returns cycles from busy to first read.
    task automatic launch(input logic [15:0] base, input string tag, output int lat);
        start_req = 1'b1; start_addr = base;
        @(negedge clk);
        start_req = 1'b0;
        check({tag, " R2 busy after accept"}, 32'(busy), 32'd1);
        check({tag, " R2 core held"}, 32'(core_rst), 32'd1);
        lat = 0;
        while (!mem_rd_en && lat < 64) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wait_release(input string tag);
        int n = 0;
        while (!run && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R7 run seen"}, 32'(run), 32'd1);
        check({tag, " R8 count at release"}, 32'(cyc_cnt), 32'd4088);
        check({tag, " R7 entry pc"}, 32'(run_pc), 32'd0);
        check({tag, " R7 busy low at release"}, 32'(busy), 32'd0);
        check({tag, " R7 core free at release"}, 32'(core_rst), 32'd0);
        @(negedge clk);
        check({tag, " R7 run single cycle"}, 32'(run), 32'd0);
        check({tag, " R7 core stays free"}, 32'(core_rst), 32'd0);
    endtask

    task automatic check_image(input logic [15:0] base, input string tag);
        int dbad = 0;
        int zbad = 0;
        for (int i = 0; i < 496; i++)
            if (rf_model[i] !== mem_word(base + 16'(i))) dbad++;
        for (int i = 496; i < 512; i++)
            if (rf_model[i] !== 32'd0) zbad++;
        check({tag, " R5 image words"}, 32'(dbad), 32'd0);
        check({tag, " R6 special cleared"}, 32'(zbad), 32'd0);
        check({tag, " R4 read count"}, 32'(rd_cnt), 32'd496);
        check({tag, " R4 address sequence"}, 32'(addr_err), 32'd0);
        check({tag, " R3 reads in slot"}, 32'(grant_err), 32'd0);
        check({tag, " R6 write count"}, 32'(wr_cnt), 32'd512);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 run", 32'(run), 32'd0);
        check("R1 core_rst", 32'(core_rst), 32'd1);
        check("R1 rd_en", 32'(mem_rd_en), 32'd0);
        check("R1 we", 32'(rf_we), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count", 32'(cyc_cnt), 32'd0);
        check("R1 idle busy", 32'(busy), 32'd0);
    endtask

    task automatic t_full(input logic [15:0] base, input int skew, input string tag);
        int lat;
        do_reset();
        arm_monitor(base);
        repeat (skew) @(negedge clk);
        launch(base, tag, lat);
        total++;
        if (lat > 7) begin
            bad++;
            $display("FAIL %s R3 first read latency actual=%0d expected<=7", tag, lat);
        end
        wait_release(tag);
        check_image(base, tag);
    endtask

    task automatic t_ignore();
        int lat;
        do_reset();
        arm_monitor(16'h0100);
        launch(16'h0100, "ignore", lat);
        repeat (300) @(negedge clk);
        start_req = 1'b1; start_addr = 16'h7000;
        @(negedge clk);
        start_req = 1'b0;
        check("ignore R9 still busy", 32'(busy), 32'd1);
        wait_release("ignore");
        check_image(16'h0100, "ignore R9");
    endtask

    task automatic t_stall();
        int lat;
        do_reset();
        arm_monitor(16'h2222);
        grant_en = 1'b0;
        start_req = 1'b1; start_addr = 16'h2222;
        @(negedge clk);
        start_req = 1'b0;
        repeat (40) @(negedge clk);
        check("stall R10 no reads", 32'(rd_cnt), 32'd0);
        check("stall R10 busy held", 32'(busy), 32'd1);
        check("stall R10 no release", 32'(run), 32'd0);
        grant_en = 1'b1;
        lat = 0;
        wait_release("stall");
        check_image(16'h2222, "stall R10");
    endtask

    task automatic t_relaunch();
        int lat;
        t_full(16'h0040, 2, "first");
        repeat (5) @(negedge clk);
        arm_monitor(16'hFF80);
        launch(16'hFF80, "relaunch", lat);
        wait_release("relaunch");
        check_image(16'hFF80, "relaunch R4 wrap");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R7 actual=no_finish expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset();
        t_full(16'h0000, 0, "base0");
        t_full(16'h1234, 5, "skew5");
        t_ignore();
        t_stall();
        t_relaunch();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule